// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the address used during a four-beat burst. When a new access starts, it captures a full start address. The upper bits are held unchanged for the whole burst. The two low bits act as a small counter that begins at the low bits of the start address.

Each clock in which the advance input is low moves the counter one beat forward. The beat order is either linear (a sum that wraps modulo four) or interleaved (the start value XOR-ed with the beat number), chosen by an order-select input. When the advance input is high, the address holds.

A sleep input freezes the block. While it is high, both loads and advances are ignored and the current address is retained. The output address comes from the registers through a small mapping stage. It therefore reflects every update right after the clock edge that makes it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_o` is all zeros.
- R2: A clock edge with `load_i`=1 and `sleep_i`=0 captures `addr_i`, and `addr_o` equals that value after the edge. This is beat 0 of the burst.
- R3: A clock edge with `step_n_i`=0, `load_i`=0 and `sleep_i`=0 moves the beat number n forward by exactly one.
- R4: With `order_sel_i`=0 (linear), `addr_o[1:0]` equals (start + n) mod 4. For example, start 2 gives 2,3,0,1.
- R5: With `order_sel_i`=1 (interleaved), `addr_o[1:0]` equals start XOR n. For example, start 1 gives 1,0,3,2.
- R6: A clock edge with `step_n_i`=1, `load_i`=0 and `sleep_i`=0 leaves `addr_o` unchanged.
- R7: After four advances, `addr_o` returns to the start address.
- R8: `addr_o[ADDR_W-1:2]` changes only on a load.
- R9: When `load_i`=1 and `step_n_i`=0 in the same cycle, the load wins. The output shows the new start address, not an advanced one.
- R10: While `sleep_i`=1, `load_i` and `step_n_i` have no effect and `addr_o` is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a new burst from `addr_i` |
| step_n_i | input | 1 | Advance one beat when low |
| order_sel_i | input | 1 | 0 = linear order, 1 = interleaved order |
| sleep_i | input | 1 | Freeze all state while high |
| addr_i | input | ADDR_W | Start address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
Every result is due one clock after its stimulus. Inputs applied before rising edge k show up on `addr_o` just after edge k, because the output is driven combinationally from registers updated at that edge. The driver applies each stimulus at a falling edge and pushes the expected address into a queue. The monitor pops one entry per rising edge, 1 ns after that edge, so each comparison sits in the cycle where the value must first appear.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef logic [1:0] beat_t;
  typedef enum logic { ORD_LINEAR = 1'b0, ORD_XOR = 1'b1 } order_e;

  // low address bits for beat n of a burst starting at base
  function automatic beat_t beat_addr(beat_t base, beat_t n, order_e ord);
    beat_t r;
    if (ord == ORD_XOR) r = base ^ n;
    else                r = base + n;
    return r;
  endfunction
endpackage

// File: rtl/bac_ctrl.sv
module bac_ctrl (
  input  logic load_i,
  input  logic step_n_i,
  input  logic sleep_i,
  output logic do_load,
  output logic do_step
);
  // priority: sleep, then load, then advance
  always_comb begin
    do_load = load_i & ~sleep_i;
    do_step = ~step_n_i & ~load_i & ~sleep_i;
  end
endmodule

// File: rtl/bac_regs.sv
module bac_regs #(
  parameter int ADDR_W = 21,
  localparam int UP_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic              do_step,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [UP_W-1:0]   upper_q,
  output logic [1:0]        base_q,
  output logic [1:0]        beat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      beat_q  <= '0;
    end else if (do_load) begin
      upper_q <= addr_i[ADDR_W-1:2];
      base_q  <= addr_i[1:0];
      beat_q  <= '0;
    end else if (do_step) begin
      beat_q  <= beat_q + 2'd1;
    end
  end
endmodule

// File: rtl/bac_order_map.sv
module bac_order_map (
  input  logic [1:0] base_q,
  input  logic [1:0] beat_q,
  input  logic       order_sel_i,
  output logic [1:0] low_o
);
  import bac_pkg::*;
  order_e ord;
  always_comb begin
    ord   = order_e'(order_sel_i);
    low_o = beat_addr(base_q, beat_q, ord);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_n_i,
  input  logic              order_sel_i,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UP_W = ADDR_W - 2;

  logic            do_load;
  logic            do_step;
  logic [UP_W-1:0] upper_q;
  logic [1:0]      base_q;
  logic [1:0]      beat_q;
  logic [1:0]      low_w;

  bac_ctrl i_ctrl (
    .load_i  (load_i),
    .step_n_i(step_n_i),
    .sleep_i (sleep_i),
    .do_load (do_load),
    .do_step (do_step)
  );

  bac_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .do_load(do_load),
    .do_step(do_step),
    .addr_i (addr_i),
    .upper_q(upper_q),
    .base_q (base_q),
    .beat_q (beat_q)
  );

  bac_order_map i_map (
    .base_q     (base_q),
    .beat_q     (beat_q),
    .order_sel_i(order_sel_i),
    .low_o      (low_w)
  );

  assign addr_o = {upper_q, low_w};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              step_n_i,
  input logic              order_sel_i,
  input logic              sleep_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              do_load,
  input logic              do_step,
  input logic [1:0]        beat_q
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !sleep_i) |=> (addr_o == $past(addr_i)));

  // R9
  load_over_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |-> !do_step);

  // R3
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_step |=> (beat_q == $past(beat_q) + 2'd1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && step_n_i && !sleep_i) |=> $stable(beat_q));

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(beat_q) && $stable(addr_o[ADDR_W-1:2])));

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && !sleep_i) |=> $stable(addr_o[ADDR_W-1:2]));

  // R4
  linear_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_step && !order_sel_i) |=>
      (order_sel_i || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .step_n_i   (step_n_i),
  .order_sel_i(order_sel_i),
  .sleep_i    (sleep_i),
  .addr_i     (addr_i),
  .addr_o     (addr_o),
  .do_load    (do_load),
  .do_step    (do_step),
  .beat_q     (beat_q)
);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int AW = 21;
  localparam int UW = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic          step_n_i = 1'b1;
  logic          order_sel_i = 1'b0;
  logic          sleep_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic [AW-1:0] exp; string tag; } item_t;
  item_t sb[$];

  logic [UW-1:0] m_up = '0;
  logic [1:0]    m_base = '0;
  logic [1:0]    m_n = '0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) i_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_n_i(step_n_i),
    .order_sel_i(order_sel_i), .sleep_i(sleep_i), .addr_i(addr_i),
    .addr_o(addr_o)
  );

  // bench model of the expected low bits, built bit by bit
  function automatic logic [AW-1:0] model_addr(logic ord);
    logic [1:0] lo;
    if (ord) lo = {m_base[1] ^ m_n[1], m_base[0] ^ m_n[0]};
    else     lo = 2'((int'(m_base) + int'(m_n)) % 4);
    return {m_up, lo};
  endfunction

  task automatic drive(input logic ld, input logic stn, input logic slp,
                       input logic ord, input logic [AW-1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    load_i = ld; step_n_i = stn; sleep_i = slp; order_sel_i = ord; addr_i = a;
    if (!slp) begin
      if (ld) begin
        m_up = a[AW-1:2]; m_base = a[1:0]; m_n = 2'd0;
      end else if (!stn) begin
        m_n = m_n + 2'd1;
      end
    end
    it.exp = model_addr(ord);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: one expected item per rising edge, sampled 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (addr_o !== it.exp) begin
          fails++;
          $display("FAIL %s: addr_o=%h expected=%h", it.tag, addr_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (addr_o !== '0) begin
      fails++;
      $display("FAIL R1: addr_o=%h expected=%h", addr_o, {AW{1'b0}});
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        a = {UW'(19'h2A5C3 + 19'(s * 1117 + ord * 733)), 2'(s)};
        drive(1'b1, 1'b1, 1'b0, 1'(ord), a, "R2");
        drive(1'b0, 1'b0, 1'b0, 1'(ord), '0, "R3");
        drive(1'b0, 1'b0, 1'b0, 1'(ord), '0, ord ? "R5" : "R4");
        drive(1'b0, 1'b1, 1'b0, 1'(ord), '1, "R6");
        drive(1'b0, 1'b1, 1'b0, 1'(ord), '0, "R6");
        drive(1'b0, 1'b0, 1'b0, 1'(ord), '1, "R8");
        drive(1'b0, 1'b0, 1'b0, 1'(ord), '0, "R7");
      end
    end

    // load wins over advance in the same cycle
    drive(1'b1, 1'b1, 1'b0, 1'b0, {19'h11111, 2'd1}, "R2");
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, "R4");
    drive(1'b1, 1'b0, 1'b0, 1'b0, {19'h0F0F0, 2'd3}, "R9");
    drive(1'b0, 1'b0, 1'b0, 1'b1, '0, "R5");

    // sleep: load and advance ignored
    drive(1'b0, 1'b1, 1'b1, 1'b1, '0, "R10");
    drive(1'b1, 1'b0, 1'b1, 1'b1, {19'h7FFFF, 2'd0}, "R10");
    drive(1'b0, 1'b0, 1'b1, 1'b1, '0, "R10");
    drive(1'b0, 1'b0, 1'b0, 1'b1, '0, "R3");

    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, "R6");
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule